// File: doc/BRIEF.md
# Reference Divider with Charge-Pump Output Routing

This block divides an incoming reference clock by a programmable ratio and drives the digital side of a phase-detector output stage. The divider emits a single-cycle pulse once every R reference cycles. R comes from a 10-bit programmed value, and the legal range is 2 to 1023. A new ratio is picked up at the divider's terminal count, so the period in progress always completes unchanged.

The output stage models a charge-pump pin as an output enable plus a data bit. In normal operation it turns the up and down pulses of a phase-frequency detector into a sourcing (enable 1, data 1) or sinking (enable 1, data 0) drive. It can swap the two pulses to suit a VCO whose frequency falls as its control voltage rises. It can also float the pin. In test mode the pin instead carries the raw output of the reference divider or of the feedback divider, so either divider can be observed directly.

The asynchronous active-low reset is synchronized internally and released on the clock. All control inputs are sampled on the reference clock.

Top module: `refdiv_cp_route`

## Requirements
- R1: With a programmed value between 2 and 1023, `ref_pulse_o` is high for exactly one cycle, and successive pulses are exactly that many clock cycles apart.
- R2: A programmed value of 0 or 1 is treated as a ratio of 2, so pulses are two cycles apart.
- R3: A change of the programmed value made between two pulses does not alter the interval in progress; the interval that follows the next pulse uses the new value.
- R4: With `test_en_i` = 0 and `hiz_req_i` = 1, `cp_oe_o` and `cp_dat_o` are 0 one cycle later whatever the up and down pulses are.
- R5: With `test_en_i` = 0, `hiz_req_i` = 0 and `pol_pos_i` = 1, an up pulse alone gives `cp_oe_o` = 1, `cp_dat_o` = 1 one cycle later, and a down pulse alone gives `cp_oe_o` = 1, `cp_dat_o` = 0.
- R6: With `test_en_i` = 0, `hiz_req_i` = 0 and `pol_pos_i` = 0, the pulses are swapped: an up pulse alone gives `cp_oe_o` = 1, `cp_dat_o` = 0, and a down pulse alone gives `cp_oe_o` = 1, `cp_dat_o` = 1.
- R7: In normal mode (`test_en_i` = 0, `hiz_req_i` = 0), when both pulses or neither pulse are present, `cp_oe_o` = 0 and `cp_dat_o` = 0 one cycle later.
- R8: With `test_en_i` = 1 and `pol_pos_i` = 0, `cp_oe_o` = 1 and `cp_dat_o` equals the value `ref_pulse_o` had in the previous cycle, whatever `hiz_req_i` is.
- R9: With `test_en_i` = 1 and `pol_pos_i` = 1, `cp_oe_o` = 1 and `cp_dat_o` equals the value `fb_div_i` had in the previous cycle, whatever `hiz_req_i` is.
- R10: While `rst_ni` is low, `ref_pulse_o`, `cp_oe_o` and `cp_dat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_val_i | input | 10 | Programmed reference divide ratio |
| hiz_req_i | input | 1 | Float the charge-pump output in normal mode |
| pol_pos_i | input | 1 | 1: positive VCO sense (or feedback route in test); 0: negative sense (or reference route in test) |
| test_en_i | input | 1 | Route a divider output to the charge-pump pin |
| fb_div_i | input | 1 | Feedback (N) divider output |
| pfd_up_i | input | 1 | Up pulse from the phase-frequency detector |
| pfd_dn_i | input | 1 | Down pulse from the phase-frequency detector |
| ref_pulse_o | output | 1 | Divided reference pulse, one cycle wide |
| cp_oe_o | output | 1 | Charge-pump output enable (0 = high impedance) |
| cp_dat_o | output | 1 | Charge-pump drive value (1 = source, 0 = sink) |

## Verification
The charge-pump outputs are registered, so each result is due one clock edge after the inputs that cause it. The driver applies inputs on the falling edge and queues the expected pair. The monitor reads the outputs just after the next rising edge. In the reference-route test, the expected data is the value of `ref_pulse_o` seen on that same falling edge. Divider results are checked by counting falling edges between pulses. The interval right after a ratio change is either discarded or checked against the old ratio, as R3 requires.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Source selected for the modelled charge-pump pin
  typedef enum logic [1:0] {
    RT_PUMP = 2'd0,  // phase detector drives source/sink
    RT_OFF  = 2'd1,  // output floated
    RT_RDIV = 2'd2,  // reference divider pulse observed
    RT_NDIV = 2'd3   // feedback divider pulse observed
  } cp_route_e;

  typedef struct packed {
    logic oe;
    logic dat;
  } cp_drive_t;

endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  generate
    if (STAGES <= 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q <= 1'b0;
        else          sync_q <= 1'b1;
      end
      assign rst_no = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q <= '0;
        else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign rst_no = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int DIV_W   = 10,
  parameter int MIN_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             pulse_o
);

  localparam logic [DIV_W-1:0] FALLBACK = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] ratio_eff;
  logic             pulse_q, pulse_d;
  logic             term;
  logic             cnt_en;

  // Prohibited ratios fall back to the minimum legal ratio
  always_comb begin
    ratio_eff = (ratio_i < FALLBACK) ? FALLBACK : ratio_i;
    term      = (cnt_q == '0);
    cnt_en    = 1'b1;
    pulse_d   = term;
    cnt_d     = cnt_q;
    if (cnt_en) begin
      if (term) cnt_d = ratio_eff - ONE;   // ratio sampled only here
      else      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // Two pulses are never adjacent: the ratio is at least 2
  assert_pulse_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // A pulse follows only an exhausted count
  assert_pulse_at_term_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> ($past(cnt_q) == '0));

  // Mid-period the count keeps moving down, so no pulse is produced
  assert_no_early_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > ONE) |=> !pulse_q);

endmodule

// File: rtl/refdiv_cp_path.sv
module refdiv_cp_path
  import refdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_i,
  input  logic hiz_i,
  input  logic pol_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic rdiv_i,
  input  logic ndiv_i,
  output logic oe_o,
  output logic dat_o
);

  cp_route_e route;
  cp_drive_t drv_d, drv_q;
  logic      up_eff, dn_eff;

  // Route decode: test mode overrides the float request
  always_comb begin
    if (test_i)     route = pol_i ? RT_NDIV : RT_RDIV;
    else if (hiz_i) route = RT_OFF;
    else            route = RT_PUMP;
  end

  // Negative VCO sense swaps the pulses
  always_comb begin
    up_eff = pol_i ? up_i : dn_i;
    dn_eff = pol_i ? dn_i : up_i;
  end

  always_comb begin
    drv_d = '0;
    unique case (route)
      RT_PUMP: begin
        drv_d.oe  = up_eff ^ dn_eff;
        drv_d.dat = up_eff & ~dn_eff;
      end
      RT_OFF:  drv_d = '0;
      RT_RDIV: begin
        drv_d.oe  = 1'b1;
        drv_d.dat = rdiv_i;
      end
      RT_NDIV: begin
        drv_d.oe  = 1'b1;
        drv_d.dat = ndiv_i;
      end
      default: drv_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else         drv_q <= drv_d;
  end

  assign oe_o  = drv_q.oe;
  assign dat_o = drv_q.dat;

  assert_float_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && hiz_i) |=> (!oe_o && !dat_o));

  assert_pos_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !hiz_i && pol_i && up_i && !dn_i) |=> (oe_o && dat_o));

  assert_neg_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !hiz_i && !pol_i && up_i && !dn_i) |=> (oe_o && !dat_o));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !hiz_i && (up_i == dn_i)) |=> (!oe_o && !dat_o));

  assert_rroute_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && !pol_i) |=> (oe_o && (dat_o == $past(rdiv_i))));

  assert_nroute_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && pol_i) |=> (oe_o && (dat_o == $past(ndiv_i))));

endmodule

// File: rtl/refdiv_cp_route.sv
module refdiv_cp_route #(
  parameter int DIV_W       = 10,
  parameter int MIN_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             hiz_req_i,
  input  logic             pol_pos_i,
  input  logic             test_en_i,
  input  logic             fb_div_i,
  input  logic             pfd_up_i,
  input  logic             pfd_dn_i,
  output logic             ref_pulse_o,
  output logic             cp_oe_o,
  output logic             cp_dat_o
);

  logic rst_n;
  logic ref_pulse;

  refdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  refdiv_counter #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .ratio_i (div_val_i),
    .pulse_o (ref_pulse)
  );

  refdiv_cp_path u_path (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .test_i (test_en_i),
    .hiz_i  (hiz_req_i),
    .pol_i  (pol_pos_i),
    .up_i   (pfd_up_i),
    .dn_i   (pfd_dn_i),
    .rdiv_i (ref_pulse),
    .ndiv_i (fb_div_i),
    .oe_o   (cp_oe_o),
    .dat_o  (cp_dat_o)
  );

  assign ref_pulse_o = ref_pulse;

  // All outputs stay quiet while the external reset is asserted
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R10: assert (!ref_pulse_o && !cp_oe_o && !cp_dat_o || $isunknown(ref_pulse_o));
    end
  end

endmodule

// File: tb/tb_refdiv_cp_route.sv
module tb_refdiv_cp_route;

  localparam time CLK_P = 20ns;  // 50 MHz

  logic       clk;
  logic       rst_n;
  logic [9:0] div_val;
  logic       hiz, pol, test, fb, up, dn;
  logic       ref_pulse, cp_oe, cp_dat;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic  oe;
    logic  dat;
    string req;
  } exp_t;

  exp_t exp_q[$];

  refdiv_cp_route dut (
    .clk_i(clk), .rst_ni(rst_n), .div_val_i(div_val),
    .hiz_req_i(hiz), .pol_pos_i(pol), .test_en_i(test),
    .fb_div_i(fb), .pfd_up_i(up), .pfd_dn_i(dn),
    .ref_pulse_o(ref_pulse), .cp_oe_o(cp_oe), .cp_dat_o(cp_dat)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per rising edge, compares just after it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(cp_oe === e.oe && cp_dat === e.dat, e.req,
            int'({cp_oe, cp_dat}), int'({e.oe, e.dat}));
    end
  end

  // Driver: applies path inputs on the falling edge and queues the result due next edge
  task automatic drive_cp(input logic t, input logic h, input logic p,
                          input logic u, input logic d, input logic f, input string req);
    exp_t e;
    logic ue, de;
    @(negedge clk);
    test = t; hiz = h; pol = p; up = u; dn = d; fb = f;
    e.req = req;
    if (t) begin
      e.oe  = 1'b1;
      e.dat = p ? f : ref_pulse;
    end else if (h) begin
      e.oe = 1'b0; e.dat = 1'b0;
    end else begin
      ue = p ? u : d;
      de = p ? d : u;
      e.oe  = ue ^ de;
      e.dat = ue & ~de;
    end
    exp_q.push_back(e);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ref_pulse !== 1'b1);
  endtask

  task automatic measure(input logic [9:0] v, input int exp_per, input string req);
    int n;
    @(negedge clk);
    div_val = v;
    wait_pulse(n);
    wait_pulse(n);
    wait_pulse(n);
    check(n == exp_per, req, n, exp_per);
    @(negedge clk);
    check(ref_pulse === 1'b0, {req, " width"}, int'(ref_pulse), 0);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; div_val = 10'd5;
    hiz = 1'b0; pol = 1'b1; test = 1'b0; fb = 1'b0; up = 1'b0; dn = 1'b0;

    // R10: reset state, with stimulus that would otherwise drive the pin
    up = 1'b1; test = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(ref_pulse === 1'b0 && cp_oe === 1'b0 && cp_dat === 1'b0, "R10",
            int'({ref_pulse, cp_oe, cp_dat}), 0);
    end
    up = 1'b0; test = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: periods for several legal ratios
    measure(10'd5,    5,    "R1 div5");
    measure(10'd2,    2,    "R1 div2");
    measure(10'd3,    3,    "R1 div3");
    measure(10'd17,   17,   "R1 div17");
    measure(10'd1023, 1023, "R1 div1023");

    // R2: prohibited ratios
    measure(10'd0, 2, "R2 div0");
    measure(10'd1, 2, "R2 div1");

    // R3: change mid-interval
    @(negedge clk);
    div_val = 10'd10;
    wait_pulse(n);
    wait_pulse(n);           // now inside an interval of 10
    repeat (3) @(negedge clk);
    div_val = 10'd4;
    wait_pulse(n);
    check(n + 3 == 10, "R3 old interval", n + 3, 10);
    wait_pulse(n);
    check(n == 4, "R3 new interval", n, 4);

    // Path checks with the divider running at 3
    div_val = 10'd3;

    // R5: positive sense
    drive_cp(0, 0, 1, 1, 0, 0, "R5 up");
    drive_cp(0, 0, 1, 0, 1, 0, "R5 dn");
    // R6: negative sense
    drive_cp(0, 0, 0, 1, 0, 0, "R6 up");
    drive_cp(0, 0, 0, 0, 1, 0, "R6 dn");
    // R7: both / neither
    drive_cp(0, 0, 1, 1, 1, 0, "R7 both");
    drive_cp(0, 0, 1, 0, 0, 0, "R7 none");
    drive_cp(0, 0, 0, 1, 1, 0, "R7 both neg");
    // R4: floated regardless of pulses and polarity
    drive_cp(0, 1, 1, 1, 0, 1, "R4 up");
    drive_cp(0, 1, 0, 0, 1, 1, "R4 dn");
    drive_cp(0, 1, 1, 1, 1, 0, "R4 both");
    // R8: reference route, with and without float request
    for (int i = 0; i < 9; i++) drive_cp(1, i[0], 0, i[1], 0, 1, "R8");
    // R9: feedback route toggling
    for (int i = 0; i < 8; i++) drive_cp(1, i[1], 1, 0, 0, i[0], "R9");
    // Back to normal after test
    drive_cp(0, 0, 1, 1, 0, 0, "R5 after test");
    drive_cp(0, 0, 1, 0, 0, 0, "R7 after test");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule